// File: doc/BRIEF.md
# Shadowed DMA Transfer Counter

This block holds the byte count for DMA transfers of a SCSI-style bus controller. Software programs a 24-bit count through three byte-wide registers, least significant byte at the lowest address. These writes land in a write-side shadow copy and leave the live count alone. The live count moves only when software issues a command whose DMA flag is set. That command copies the whole shadow into the live counter in one step, so a half-written count is never seen by the data path.

The DMA side reports each byte it moves with a one-cycle strobe, and the live counter steps down by one for each. When the count steps from one to zero, the block raises a terminal-count flag, which software can read through a status register. A transfer-start pulse from the DMA engine clears that flag. If the live count is zero when the transfer starts, the block loads 65536 (0x010000) in its place.

Until software first writes the high count byte after reset, a read of that byte returns a fixed chip identifier. Driver code uses this to tell which controller variant is present.

Top module: `xfer_count_regs`

## Requirements
- R1: After reset, the live count is zero and the terminal-count flag is clear. Reads of the low byte (address 0), the middle byte (address 1) and the status register (address 4) return 0x00.
- R2: Writes to addresses 0, 1 and 2 store the low, middle and high count bytes (bits 7:0, 15:8 and 23:16) into the shadow only. Reads of addresses 0 to 2 return bytes of the live count, which these writes leave unchanged.
- R3: A write to the command register (address 3) with bit 7 set copies all three shadow bytes into the live counter on that clock edge. A command write with bit 7 clear leaves the live counter unchanged.
- R4: A write to any of addresses 0, 1 or 2 clears the terminal-count flag. This clear takes priority over a terminal-count set in the same cycle.
- R5: Each cycle with `dma_strobe` high decrements a nonzero live count by one. The decrement from one to zero sets the terminal-count flag.
- R6: A cycle with `xfer_start` high clears the terminal-count flag. If the live count is zero at that edge, it becomes 0x010000; otherwise it is kept.
- R7: Until the high count byte (address 2) has been written at least once since reset, a read of address 2 returns the chip identifier 0xA2. After that write, the read returns the live count bits 23:16.
- R8: A reload in the same cycle as a strobe loads the shadow value and ignores the strobe. A transfer start in the same cycle as a strobe also ignores the strobe.
- R9: A strobe while the live count is zero leaves it at zero, with no wrap, and leaves the terminal-count flag as it was.
- R10: A read of the status register (address 4) returns the terminal-count flag in bit 4 and zeros in all other bits. The `tc_flag` output carries the same flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per byte |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| xfer_start | input | 1 | Transfer-start pulse from the DMA engine |
| dma_strobe | input | 1 | One byte moved by the DMA engine |
| live_count | output | 24 | Current live transfer count |
| tc_flag | output | 1 | Terminal-count flag |

## Verification
The count is programmed with a multi-byte value (0x001234) and stepped down by several strobes. This shows whether the bytes sit in little-endian order and whether the shadow and live copies are kept apart, both before and after reload.

A small count of two is run down to zero and then strobed once more. This separates a correct terminal-count set at the one-to-zero step from an early set, a missing set or a wrap-around.

Transfer starts are applied on both a nonzero and a zero count, which tells the 65536 substitution apart from a plain hold. Reload and start are each issued in the same cycle as a strobe to expose the wrong priority. Reads of the high byte before and after its first write separate the identifier path from the live byte.

// File: rtl/xfer_cnt_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the transfer counter.
// Assumes: one control event set per cycle, decoded in the top module.
package xfer_cnt_pkg;

    // Control events that reach the live counter in one cycle
    typedef struct packed {
        logic reload;   // shadow copy request from a DMA-flagged command
        logic start;    // transfer start from the DMA engine
        logic dec;      // one byte moved
        logic clr_tc;   // count byte written by software
    } cnt_ctl_t;

endpackage

// File: rtl/xc_shadow_bank.sv
`timescale 1ns/1ps
// Module: xc_shadow_bank
// Holds the write-side copy of the count, one byte register per address,
// and remembers whether the top byte has been written since reset.
// Assumes: byte addresses 0..NUM_BYTES-1, little-endian packing.
module xc_shadow_bank #(
    parameter int NUM_BYTES = 3,
    parameter int ADDR_W    = 3,
    localparam int COUNT_W  = 8 * NUM_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    output logic [COUNT_W-1:0] shadow,
    output logic               cnt_byte_wr,
    output logic               hi_written
);

    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(NUM_BYTES - 1);

    // One register per count byte
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        // Capture the byte written at this address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow[8*b +: 8] <= 8'h00;
            end else if (wr_en && (wr_addr == ADDR_W'(b))) begin
                shadow[8*b +: 8] <= wr_data;
            end
        end
    end

    // Flag any write to a count byte (used to clear terminal count)
    always_comb begin
        cnt_byte_wr = wr_en && (wr_addr <= HI_ADDR);
    end

    // Sticky record of the first high-byte write since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_written <= 1'b0;
        end else if (wr_en && (wr_addr == HI_ADDR)) begin
            hi_written <= 1'b1;
        end
    end

endmodule

// File: rtl/xc_live_counter.sv
`timescale 1ns/1ps
// Module: xc_live_counter
// Live count and terminal-count flag.
// Priority for the count: reload, then start, then decrement.
// Priority for the flag: a clear beats a set.
// Assumes: at most one decrement per cycle; zero never wraps.
module xc_live_counter
    import xfer_cnt_pkg::*;
#(
    parameter int COUNT_W   = 24,
    parameter int EMPTY_EXP = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cnt_ctl_t           ctl,
    input  logic [COUNT_W-1:0] load_val,
    output logic [COUNT_W-1:0] count,
    output logic               tc
);

    localparam logic [COUNT_W-1:0] ONE       = COUNT_W'(1);
    localparam logic [COUNT_W-1:0] EMPTY_VAL = ONE << EMPTY_EXP;

    logic dec_ok;
    logic hit_zero;

    // A decrement counts only when nothing with higher priority is present
    always_comb begin
        dec_ok   = ctl.dec && !ctl.reload && !ctl.start && (count != '0);
        hit_zero = dec_ok && (count == ONE);
    end

    // Count register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ctl.reload) begin
            count <= load_val;
        end else if (ctl.start) begin
            count <= (count == '0) ? EMPTY_VAL : count;
        end else if (dec_ok) begin
            count <= count - ONE;
        end
    end

    // Terminal-count flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= 1'b0;
        end else if (ctl.clr_tc || ctl.start) begin
            tc <= 1'b0;
        end else if (hit_zero) begin
            tc <= 1'b1;
        end
    end

endmodule

// File: rtl/xc_read_mux.sv
`timescale 1ns/1ps
// Module: xc_read_mux
// Read data selection: live count bytes, chip identifier or status.
// Assumes: the command address and unused addresses read as zero.
module xc_read_mux #(
    parameter int          NUM_BYTES = 3,
    parameter int          ADDR_W    = 3,
    parameter logic [7:0]  CHIP_ID   = 8'hA2,
    parameter int          TC_BIT    = 4,
    localparam int         COUNT_W   = 8 * NUM_BYTES
) (
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [COUNT_W-1:0] count,
    input  logic               tc,
    input  logic               hi_written,
    output logic [7:0]         rd_data
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_BYTES + 1);

    // Pick the byte addressed by rd_addr
    always_comb begin
        rd_data = 8'h00;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (rd_addr == ADDR_W'(b)) begin
                rd_data = count[8*b +: 8];
            end
        end
        if ((rd_addr == ADDR_W'(NUM_BYTES - 1)) && !hi_written) begin
            rd_data = CHIP_ID;
        end
        if (rd_addr == STAT_ADDR) begin
            rd_data = 8'(tc) << TC_BIT;
        end
    end

endmodule

// File: rtl/xfer_count_regs.sv
`timescale 1ns/1ps
// Module: xfer_count_regs (top)
// Shadowed DMA transfer counter with byte-wide register access.
// Address map: 0..NUM_BYTES-1 count bytes (low first),
// NUM_BYTES command, NUM_BYTES+1 status.
// Assumes: reg_wr is a one-cycle pulse per byte; the read port is combinational.
module xfer_count_regs
    import xfer_cnt_pkg::*;
#(
    parameter int         NUM_BYTES = 3,
    parameter logic [7:0] CHIP_ID   = 8'hA2,
    parameter int         DMA_BIT   = 7,
    parameter int         TC_BIT    = 4,
    parameter int         EMPTY_EXP = 16,
    localparam int        COUNT_W   = 8 * NUM_BYTES,
    localparam int        ADDR_W    = $clog2(NUM_BYTES + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               xfer_start,
    input  logic               dma_strobe,
    output logic [COUNT_W-1:0] live_count,
    output logic               tc_flag
);

    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_BYTES);

    logic [COUNT_W-1:0] shadow_q;
    logic               cnt_byte_wr;
    logic               hi_written;
    cnt_ctl_t           ctl;

    // Decode control events for the live counter
    always_comb begin
        ctl.reload = reg_wr && (reg_addr == CMD_ADDR) && reg_wdata[DMA_BIT];
        ctl.start  = xfer_start;
        ctl.dec    = dma_strobe;
        ctl.clr_tc = cnt_byte_wr;
    end

    xc_shadow_bank #(
        .NUM_BYTES (NUM_BYTES),
        .ADDR_W    (ADDR_W)
    ) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .wr_addr     (reg_addr),
        .wr_data     (reg_wdata),
        .shadow      (shadow_q),
        .cnt_byte_wr (cnt_byte_wr),
        .hi_written  (hi_written)
    );

    xc_live_counter #(
        .COUNT_W   (COUNT_W),
        .EMPTY_EXP (EMPTY_EXP)
    ) u_live (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .load_val (shadow_q),
        .count    (live_count),
        .tc       (tc_flag)
    );

    xc_read_mux #(
        .NUM_BYTES (NUM_BYTES),
        .ADDR_W    (ADDR_W),
        .CHIP_ID   (CHIP_ID),
        .TC_BIT    (TC_BIT)
    ) u_rd (
        .rd_addr    (reg_addr),
        .count      (live_count),
        .tc         (tc_flag),
        .hi_written (hi_written),
        .rd_data    (reg_rdata)
    );

endmodule

// File: rtl/xc_checker.sv
`timescale 1ns/1ps
// Module: xc_checker
// Temporal properties of the transfer counter, bound to the top module.
module xc_checker #(
    parameter int         NUM_BYTES = 3,
    parameter logic [7:0] CHIP_ID   = 8'hA2,
    parameter int         DMA_BIT   = 7,
    parameter int         EMPTY_EXP = 16,
    localparam int        COUNT_W   = 8 * NUM_BYTES,
    localparam int        ADDR_W    = $clog2(NUM_BYTES + 2)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [7:0]         reg_wdata,
    input logic [7:0]         reg_rdata,
    input logic               xfer_start,
    input logic               dma_strobe,
    input logic [COUNT_W-1:0] live_count,
    input logic               tc_flag,
    input logic [COUNT_W-1:0] shadow_q,
    input logic               hi_written
);

    localparam logic [ADDR_W-1:0]  HI_ADDR   = ADDR_W'(NUM_BYTES - 1);
    localparam logic [ADDR_W-1:0]  CMD_ADDR  = ADDR_W'(NUM_BYTES);
    localparam logic [COUNT_W-1:0] ONE       = COUNT_W'(1);
    localparam logic [COUNT_W-1:0] EMPTY_VAL = ONE << EMPTY_EXP;

    logic reload_cmd;
    logic plain_cmd;
    assign reload_cmd = reg_wr && (reg_addr == CMD_ADDR) && reg_wdata[DMA_BIT];
    assign plain_cmd  = reg_wr && (reg_addr == CMD_ADDR) && !reg_wdata[DMA_BIT];

    p_reload_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reload_cmd |=> (live_count == $past(shadow_q)));

    p_plain_cmd_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        plain_cmd && !xfer_start && !dma_strobe |=> $stable(live_count));

    p_byte_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr <= HI_ADDR) |=> !tc_flag);

    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_strobe && !reload_cmd && !xfer_start && (live_count != '0)
        |=> (live_count == $past(live_count) - ONE));

    p_tc_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_strobe && !reload_cmd && !xfer_start && (live_count == ONE)
        && !(reg_wr && (reg_addr <= HI_ADDR)) |=> tc_flag);

    p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !tc_flag);

    p_start_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start && !reload_cmd && (live_count == '0) |=> (live_count == EMPTY_VAL));

    p_chip_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_written && (reg_addr == HI_ADDR) |-> (reg_rdata == CHIP_ID));

    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_strobe && !reload_cmd && !xfer_start && (live_count == '0)
        |=> (live_count == '0));

endmodule

bind xfer_count_regs xc_checker #(
    .NUM_BYTES (NUM_BYTES),
    .CHIP_ID   (CHIP_ID),
    .DMA_BIT   (DMA_BIT),
    .EMPTY_EXP (EMPTY_EXP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .xfer_start (xfer_start),
    .dma_strobe (dma_strobe),
    .live_count (live_count),
    .tc_flag    (tc_flag),
    .shadow_q   (shadow_q),
    .hi_written (hi_written)
);

// File: tb/xfer_count_regs_tb.sv
`timescale 1ns/1ps
// Directed bench for xfer_count_regs: one task per scenario.
module xfer_count_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        xfer_start = 1'b0;
    logic        dma_strobe = 1'b0;
    logic [23:0] live_count;
    logic        tc_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xfer_count_regs dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .xfer_start (xfer_start),
        .dma_strobe (dma_strobe),
        .live_count (live_count),
        .tc_flag    (tc_flag)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // Read a register between edges and compare
    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic strobe(input int n);
        @(negedge clk);
        dma_strobe = 1'b1;
        repeat (n) @(negedge clk);
        dma_strobe = 1'b0;
    endtask

    task automatic start_pulse();
        @(negedge clk);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic t_reset();
        rd_check("R1 low after reset", 3'd0, 8'h00);
        rd_check("R1 mid after reset", 3'd1, 8'h00);
        rd_check("R1 status after reset", 3'd4, 8'h00);
        check("R1 tc_flag after reset", {7'b0, tc_flag}, 8'h00);
        rd_check("R7 chip id before high write", 3'd2, 8'hA2);
    endtask

    task automatic t_shadow_reload();
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd_check("R2 live low unchanged by shadow write", 3'd0, 8'h00);
        rd_check("R7 chip id still before high write", 3'd2, 8'hA2);
        wr(3'd2, 8'h00);
        rd_check("R7 high reads live after write", 3'd2, 8'h00);
        wr(3'd3, 8'h01);
        rd_check("R3 no reload without DMA bit", 3'd0, 8'h00);
        wr(3'd3, 8'h80);
        rd_check("R3 reload low", 3'd0, 8'h34);
        rd_check("R2 reload mid (little-endian)", 3'd1, 8'h12);
        rd_check("R2 reload high", 3'd2, 8'h00);
    endtask

    task automatic t_decrement();
        start_pulse();
        rd_check("R6 start keeps nonzero count", 3'd0, 8'h34);
        strobe(3);
        rd_check("R5 three strobes", 3'd0, 8'h31);
        rd_check("R5 mid after strobes", 3'd1, 8'h12);
        wr(3'd0, 8'h02); wr(3'd1, 8'h00); wr(3'd3, 8'h80);
        strobe(1);
        rd_check("R5 count one", 3'd0, 8'h01);
        rd_check("R5 no tc before zero", 3'd4, 8'h00);
        strobe(1);
        rd_check("R5 count zero", 3'd0, 8'h00);
        rd_check("R10 status shows tc in bit 4", 3'd4, 8'h10);
        check("R10 tc_flag output", {7'b0, tc_flag}, 8'h01);
        strobe(1);
        rd_check("R9 no wrap low", 3'd0, 8'h00);
        rd_check("R9 no wrap high", 3'd2, 8'h00);
        rd_check("R9 tc kept", 3'd4, 8'h10);
    endtask

    task automatic t_tc_clear();
        wr(3'd1, 8'h00);
        rd_check("R4 byte write clears tc", 3'd4, 8'h00);
    endtask

    task automatic t_empty_start();
        wr(3'd0, 8'h01); wr(3'd3, 8'h80);
        strobe(1);
        rd_check("R5 tc set before start", 3'd4, 8'h10);
        start_pulse();
        rd_check("R6 start clears tc", 3'd4, 8'h00);
        rd_check("R6 zero start high byte", 3'd2, 8'h01);
        rd_check("R6 zero start mid byte", 3'd1, 8'h00);
        rd_check("R6 zero start low byte", 3'd0, 8'h00);
    endtask

    task automatic t_collide();
        wr(3'd0, 8'h05);
        @(negedge clk);
        dma_strobe = 1'b1; reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h80;
        @(negedge clk);
        dma_strobe = 1'b0; reg_wr = 1'b0;
        rd_check("R8 reload beats strobe low", 3'd0, 8'h05);
        rd_check("R8 reload beats strobe high", 3'd2, 8'h00);
        @(negedge clk);
        dma_strobe = 1'b1; xfer_start = 1'b1;
        @(negedge clk);
        dma_strobe = 1'b0; xfer_start = 1'b0;
        rd_check("R8 start beats strobe", 3'd0, 8'h05);
        strobe(1);
        rd_check("R5 plain strobe after collisions", 3'd0, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shadow_reload();
        t_decrement();
        t_tc_clear();
        t_empty_start();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule